// File: doc/BRIEF.md
# Dual-Clock FIFO with Ready Flags

This block is a first-in, first-out buffer that carries 18-bit words from a write port, clocked by `wr_clk`, to a read port, clocked by `rd_clk`. The two clocks are free-running and independent of each other. Each side has its own chip select and direction select. The write side accepts a word only while its input-ready flag `a_ready` is high. The read side shows the oldest word in an output register, and its output-ready flag `b_valid` says that the register holds a word that has not yet been read.

The first word written into an empty buffer is moved into the output register without any read request, at the same edge that raises `b_valid`. Once every stored word has been read, `b_valid` drops and the last word stays visible. The memory holds 2^ADDR_W words (512 by default). The output register holds one more, so the buffer accepts 513 words before `a_ready` falls.

The read port produces an output-enable signal, `b_oe`, for pad-level drivers outside the block. Reset `rst` is active high. It is sampled directly by the write clock and through a two-stage synchroniser by the read clock, and it must be held for at least four rising edges of each clock.

Top module: `xclk_ready_fifo`

## Requirements
- R1: A word on `a_din` is stored at a rising `wr_clk` if and only if `a_cs_n` is 0, `a_dir` is 1, `a_wen` is 1 and `a_ready` is 1. Any other combination stores nothing.
- R2: A read is accepted at a rising `rd_clk` if and only if `b_cs_n` is 0, `b_dir` is 0, `b_ren` is 1 and `b_valid` is 1. An accepted read replaces `b_dout` with the next word, and any other combination leaves `b_dout` unchanged.
- R3: `b_oe` is 1 exactly when `b_cs_n` is 0 and `b_dir` is 0, and is 0 for the other three combinations.
- R4: `a_ready` is 0 once 2^ADDR_W+1 words are held, counting the word in the output register. Write attempts while `a_ready` is 0 are ignored.
- R5: `b_valid` is 0 when no unread word is present. A read request made while `b_valid` is 0 consumes nothing.
- R6: After a word is written into an empty buffer, `b_valid` stays 0 at the first and second rising `rd_clk` that follow the write. It becomes 1 at the third, and at that same edge `b_dout` takes the written word.
- R7: After the last word is read and `b_valid` falls, `b_dout` keeps that last word until `b_valid` rises again.
- R8: While `rst` is held for at least four rising edges of each clock, `a_ready` and `b_valid` are 0. Words stored before the reset are discarded.
- R9: After `rst` is released, `a_ready` is still 0 following the first rising `wr_clk` and becomes 1 at the second.
- R10: Words leave in the order they were written, including runs longer than the memory depth that wrap both pointers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset for both sides |
| a_cs_n | input | 1 | Write-side chip select, active low |
| a_dir | input | 1 | Write-side direction, 1 selects write |
| a_wen | input | 1 | Write enable |
| a_din | input | DATA_W | Write data |
| a_ready | output | 1 | Input-ready flag, 0 when full |
| b_cs_n | input | 1 | Read-side chip select, active low |
| b_dir | input | 1 | Read-side direction, 0 selects read |
| b_ren | input | 1 | Read enable |
| b_dout | output | DATA_W | Output register |
| b_oe | output | 1 | Output enable for external drivers |
| b_valid | output | 1 | Output-ready flag, 1 when `b_dout` holds an unread word |

## Verification
The gating table drives all eight settings of chip select, direction and enable on each side. It tells the single accepting setting apart from settings that differ from it in only one signal. A single word written into an empty buffer measures the fall-through delay, and the following reads show the last word being held and a read on an empty buffer consuming nothing. Filling the buffer without reading shows that the threshold is exactly one word beyond the memory depth and that overflow attempts are dropped. Draining that run checks order across pointer wrap. A reset applied with data in the buffer shows that the stored words are discarded, and it repeats the two-edge release timing of `a_ready`.

// File: rtl/xrf_pkg.sv
package xrf_pkg;
  // Binary to reflected Gray code, evaluated on a 32-bit container.
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/xrf_sync.sv
module xrf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/xrf_ram.sv
module xrf_ram #(
  parameter int DW = 18,
  parameter int AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read with enable: the read register doubles as the output register.
  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/xrf_wr_ctl.sv
module xrf_wr_ctl #(
  parameter int AW = 9,
  parameter int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          dir,
  input  logic          en,
  input  logic [PW-1:0] rgray_s,
  output logic          ready,
  output logic [PW-1:0] wgray,
  output logic [AW-1:0] waddr,
  output logic          we
);
  logic [PW-1:0] wbin_q, wbin_nx, wgray_nx, full_pat;
  logic          live_q, fire, full_nx;

  assign fire     = ~cs_n & dir & en & ready;
  assign wbin_nx  = wbin_q + PW'(fire);
  assign wgray_nx = PW'(xrf_pkg::to_gray(32'(wbin_nx)));
  // Full: write pointer one lap ahead of the synchronised read pointer.
  assign full_pat = {~rgray_s[PW-1 -: 2], rgray_s[PW-3:0]};
  assign full_nx  = (wgray_nx == full_pat);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin_q <= '0;
      wgray  <= '0;
      live_q <= 1'b0;
      ready  <= 1'b0;
    end else begin
      wbin_q <= wbin_nx;
      wgray  <= wgray_nx;
      live_q <= 1'b1;
      ready  <= live_q & ~full_nx;
    end
  end

  assign we    = fire;
  assign waddr = wbin_q[AW-1:0];
endmodule

// File: rtl/xrf_rd_ctl.sv
module xrf_rd_ctl #(
  parameter int AW = 9,
  parameter int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          dir,
  input  logic          en,
  input  logic [PW-1:0] wgray_s,
  output logic          valid,
  output logic          oe,
  output logic [PW-1:0] rgray,
  output logic [AW-1:0] raddr,
  output logic          re
);
  logic [PW-1:0] rbin_q, rbin_nx;
  logic          fire, has_data, load;

  assign fire     = ~cs_n & ~dir & en & valid;
  assign has_data = (rgray != wgray_s);
  // Prefetch into the output register when it is empty or being consumed.
  assign load     = ~rst & has_data & (~valid | fire);
  assign rbin_nx  = rbin_q + PW'(load);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin_q <= '0;
      rgray  <= '0;
      valid  <= 1'b0;
    end else begin
      rbin_q <= rbin_nx;
      rgray  <= PW'(xrf_pkg::to_gray(32'(rbin_nx)));
      if (load)      valid <= 1'b1;
      else if (fire) valid <= 1'b0;
    end
  end

  assign re    = load;
  assign raddr = rbin_q[AW-1:0];
  assign oe    = ~cs_n & ~dir;
endmodule

// File: rtl/xclk_ready_fifo.sv
module xclk_ready_fifo #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 9
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              a_cs_n,
  input  logic              a_dir,
  input  logic              a_wen,
  input  logic [DATA_W-1:0] a_din,
  output logic              a_ready,
  input  logic              b_cs_n,
  input  logic              b_dir,
  input  logic              b_ren,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  output logic              b_valid
);
  localparam int PTR_W = ADDR_W + 1;

  logic              rst_r;
  logic [PTR_W-1:0]  wgray_w, rgray_r, rgray_ws, wgray_rs;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              we, re;

  // Reset brought into the read domain.
  xrf_sync #(.W(1), .STAGES(2)) u_rst_sync (
    .clk(rd_clk), .rst(1'b0), .d(rst), .q(rst_r)
  );

  xrf_sync #(.W(PTR_W), .STAGES(2)) u_r2w (
    .clk(wr_clk), .rst(rst), .d(rgray_r), .q(rgray_ws)
  );

  xrf_sync #(.W(PTR_W), .STAGES(2)) u_w2r (
    .clk(rd_clk), .rst(rst_r), .d(wgray_w), .q(wgray_rs)
  );

  xrf_wr_ctl #(.AW(ADDR_W), .PW(PTR_W)) u_wr (
    .clk(wr_clk), .rst(rst), .cs_n(a_cs_n), .dir(a_dir), .en(a_wen),
    .rgray_s(rgray_ws), .ready(a_ready), .wgray(wgray_w),
    .waddr(waddr), .we(we)
  );

  xrf_rd_ctl #(.AW(ADDR_W), .PW(PTR_W)) u_rd (
    .clk(rd_clk), .rst(rst_r), .cs_n(b_cs_n), .dir(b_dir), .en(b_ren),
    .wgray_s(wgray_rs), .valid(b_valid), .oe(b_oe), .rgray(rgray_r),
    .raddr(raddr), .re(re)
  );

  xrf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(a_din),
    .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(b_dout)
  );
endmodule

// File: rtl/xclk_ready_fifo_chk.sv
module xclk_ready_fifo_chk #(
  parameter int DATA_W = 18,
  parameter int PTR_W  = 10
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              a_cs_n,
  input logic              a_dir,
  input logic              a_wen,
  input logic              a_ready,
  input logic              b_cs_n,
  input logic              b_dir,
  input logic              b_ren,
  input logic              b_valid,
  input logic [DATA_W-1:0] b_dout,
  input logic [PTR_W-1:0]  wgray,
  input logic [PTR_W-1:0]  rgray
);
  // R9: still not ready after the first write edge following release
  p_ready_second_edge_r9: assert property (@(posedge wr_clk) disable iff (rst)
    ($past(rst, 2) && !$past(rst)) |-> !a_ready);

  // R4: input-ready only falls after an attempted write
  p_ready_fall_on_write_r4: assert property (@(posedge wr_clk) disable iff (rst)
    $fell(a_ready) |-> $past(!a_cs_n && a_dir && a_wen));

  // R5: output-ready only falls after an accepted read request
  p_valid_fall_on_read_r5: assert property (@(posedge rd_clk) disable iff (rst)
    $fell(b_valid) |-> $past(!b_cs_n && !b_dir && b_ren));

  // R7: output register frozen while no unread word is present
  p_hold_on_empty_r7: assert property (@(posedge rd_clk) disable iff (rst)
    !b_valid |=> (b_valid || $stable(b_dout)));

  // R10: crossing pointers change by at most one bit per edge
  p_wgray_step_r10: assert property (@(posedge wr_clk) disable iff (rst)
    $onehot0(wgray ^ $past(wgray)));

  p_rgray_step_r10: assert property (@(posedge rd_clk) disable iff (rst)
    $onehot0(rgray ^ $past(rgray)));
endmodule

bind xclk_ready_fifo xclk_ready_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .a_cs_n(a_cs_n), .a_dir(a_dir), .a_wen(a_wen), .a_ready(a_ready),
  .b_cs_n(b_cs_n), .b_dir(b_dir), .b_ren(b_ren), .b_valid(b_valid),
  .b_dout(b_dout), .wgray(wgray_w), .rgray(rgray_r)
);

// File: tb/xclk_ready_fifo_tb.sv
module xclk_ready_fifo_tb;
  localparam int DW    = 18;
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
  logic a_cs_n = 1'b1, a_dir = 1'b0, a_wen = 1'b0;
  logic [DW-1:0] a_din = '0;
  logic b_cs_n = 1'b1, b_dir = 1'b0, b_ren = 1'b0;
  logic a_ready, b_oe, b_valid;
  logic [DW-1:0] b_dout;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] q[$];

  // {side(0 write,1 read), cs_n, dir, en, accepted}
  localparam logic [4:0] TAB [16] = '{
    5'b0_1000, 5'b0_1010, 5'b0_1100, 5'b0_1110,
    5'b0_0000, 5'b0_0010, 5'b0_0100, 5'b0_0111,
    5'b1_1000, 5'b1_1010, 5'b1_1100, 5'b1_1110,
    5'b1_0011, 5'b1_0100, 5'b1_0110, 5'b1_0000
  };

  xclk_ready_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
    .a_cs_n(a_cs_n), .a_dir(a_dir), .a_wen(a_wen), .a_din(a_din), .a_ready(a_ready),
    .b_cs_n(b_cs_n), .b_dir(b_dir), .b_ren(b_ren), .b_dout(b_dout),
    .b_oe(b_oe), .b_valid(b_valid)
  );

  always #10 wr_clk = ~wr_clk;
  initial begin
    #7;
    forever begin rd_clk = 1'b1; #13; rd_clk = 1'b0; #13; end
  end

  function automatic logic [DW-1:0] pat(input int k);
    return DW'(k * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_idle();
    a_cs_n = 1'b1; a_dir = 1'b0; a_wen = 1'b0;
  endtask

  task automatic rd_idle();
    b_cs_n = 1'b1; b_dir = 1'b0; b_ren = 1'b0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    a_cs_n = 1'b0; a_dir = 1'b1; a_wen = 1'b1; a_din = d;
    @(negedge wr_clk);
    wr_idle();
  endtask

  task automatic pop(output logic [DW-1:0] d, output bit ok);
    ok = 0; d = '0;
    for (int t = 0; t < 40 && !ok; t++) begin
      @(negedge rd_clk);
      if (b_valid) begin
        d = b_dout; ok = 1;
        b_cs_n = 1'b0; b_dir = 1'b0; b_ren = 1'b1;
      end
    end
    @(negedge rd_clk);
    rd_idle();
  endtask

  task automatic do_reset();
    @(negedge wr_clk); rst = 1'b1;
    repeat (8) @(negedge wr_clk);
    chk(a_ready == 1'b0, "R8 ready in reset", 32'(a_ready), 0);
    @(negedge rd_clk);
    chk(b_valid == 1'b0, "R8 valid in reset", 32'(b_valid), 0);
    @(negedge wr_clk); rst = 1'b0;
    @(negedge wr_clk);
    chk(a_ready == 1'b0, "R9 ready after first edge", 32'(a_ready), 0);
    @(negedge wr_clk);
    chk(a_ready == 1'b1, "R9 ready after second edge", 32'(a_ready), 1);
    repeat (6) @(negedge rd_clk);
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, head;
    bit ok;
    int cnt, stall;

    do_reset();

    // R6: fall-through latency of the first word
    @(negedge wr_clk);
    a_cs_n = 1'b0; a_dir = 1'b1; a_wen = 1'b1; a_din = 18'h1A5C3;
    @(posedge wr_clk);
    fork
      begin @(negedge wr_clk); wr_idle(); end
      begin
        for (int k = 1; k <= 3; k++) begin
          @(posedge rd_clk); @(negedge rd_clk);
          if (k < 3) chk(b_valid == 1'b0, "R6 valid early", 32'(b_valid), 0);
          else begin
            chk(b_valid == 1'b1, "R6 valid at third edge", 32'(b_valid), 1);
            chk(b_dout == 18'h1A5C3, "R6 data at third edge", 32'(b_dout), 32'h1A5C3);
          end
        end
      end
    join

    pop(d, ok);
    chk(ok && d == 18'h1A5C3, "R2 pop first word", 32'(d), 32'h1A5C3);
    // R7: last word held after emptying
    for (int k = 0; k < 4; k++) begin
      @(negedge rd_clk);
      chk(b_valid == 1'b0, "R7 valid low after empty", 32'(b_valid), 0);
      chk(b_dout == 18'h1A5C3, "R7 last word held", 32'(b_dout), 32'h1A5C3);
    end
    // R5: read request while empty consumes nothing
    b_cs_n = 1'b0; b_dir = 1'b0; b_ren = 1'b1;
    repeat (3) @(negedge rd_clk);
    chk(b_valid == 1'b0, "R5 valid low on empty read", 32'(b_valid), 0);
    chk(b_dout == 18'h1A5C3, "R5 output unchanged on empty read", 32'(b_dout), 32'h1A5C3);
    rd_idle();
    push(18'h0BEEF);
    pop(d, ok);
    chk(ok && d == 18'h0BEEF, "R5 next word delivered", 32'(d), 32'h0BEEF);
    repeat (8) @(negedge rd_clk);
    chk(b_valid == 1'b0, "R5 no extra word", 32'(b_valid), 0);

    // R3: output enable for each select combination
    for (int c = 0; c < 4; c++) begin
      @(negedge rd_clk);
      b_cs_n = c[1]; b_dir = c[0]; b_ren = 1'b0;
      #1;
      chk(b_oe == (c == 0), "R3 output enable", 32'(b_oe), 32'(c == 0));
    end
    rd_idle();

    // Gating table: preload, then walk
    for (int k = 0; k < 10; k++) begin
      push(pat(k + 1000));
      q.push_back(pat(k + 1000));
    end
    for (int i = 0; i < 16; i++) begin
      if (!TAB[i][4]) begin
        @(negedge wr_clk);
        a_cs_n = TAB[i][3]; a_dir = TAB[i][2]; a_wen = TAB[i][1]; a_din = pat(2000 + i);
        if (TAB[i][0]) q.push_back(pat(2000 + i));
        @(negedge wr_clk);
        wr_idle();
      end else begin
        ok = 0;
        for (int t = 0; t < 40 && !ok; t++) begin
          @(negedge rd_clk);
          ok = b_valid;
        end
        head = q[0];
        chk(b_dout == head, "R2 head before request", 32'(b_dout), 32'(head));
        b_cs_n = TAB[i][3]; b_dir = TAB[i][2]; b_ren = TAB[i][1];
        @(negedge rd_clk);
        rd_idle();
        if (TAB[i][0]) begin
          void'(q.pop_front());
          chk(b_valid && b_dout == q[0], "R2 accepted read advances", 32'(b_dout), 32'(q[0]));
        end else begin
          chk(b_dout == head, "R2 rejected read holds", 32'(b_dout), 32'(head));
        end
      end
    end
    // R1: drain; only the accepted table write may appear
    while (q.size() > 0) begin
      head = q.pop_front();
      pop(d, ok);
      chk(ok && d == head, "R1 stored sequence", 32'(d), 32'(head));
    end
    repeat (10) @(negedge rd_clk);
    chk(b_valid == 1'b0, "R1 rejected writes not stored", 32'(b_valid), 0);

    // R8: reset discards stored words
    for (int k = 0; k < 5; k++) push(pat(3000 + k));
    repeat (10) @(negedge rd_clk);
    do_reset();
    repeat (20) @(negedge rd_clk);
    chk(b_valid == 1'b0, "R8 contents discarded", 32'(b_valid), 0);

    // R4: fill without reading
    cnt = 0; stall = 0;
    while (stall < 8) begin
      @(negedge wr_clk);
      if (a_ready && cnt < 600) begin
        a_cs_n = 1'b0; a_dir = 1'b1; a_wen = 1'b1; a_din = pat(cnt);
        cnt++; stall = 0;
      end else begin
        a_cs_n = 1'b0; a_dir = 1'b1; a_wen = 1'b1; a_din = 18'h3FFFF;
        stall++;
      end
    end
    @(negedge wr_clk);
    wr_idle();
    chk(cnt == DEPTH + 1, "R4 words accepted before full", 32'(cnt), 32'(DEPTH + 1));
    chk(a_ready == 1'b0, "R4 ready low when full", 32'(a_ready), 0);

    // R10: drain across wrap, overflow attempts absent
    for (int k = 0; k <= DEPTH; k++) begin
      pop(d, ok);
      if (!ok || d != pat(k)) chk(0, "R10 order across wrap", 32'(d), 32'(pat(k)));
    end
    chk(1, "R10 order across wrap", 0, 0);
    repeat (10) @(negedge rd_clk);
    chk(b_valid == 1'b0, "R4 overflow word not stored", 32'(b_valid), 0);
    chk(b_dout == pat(DEPTH), "R7 final word held", 32'(b_dout), 32'(pat(DEPTH)));
    @(negedge wr_clk);
    chk(a_ready == 1'b1, "R4 ready back after drain", 32'(a_ready), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule